// File: doc/BRIEF.md
# Scaled Integer Add/Subtract Unit

A single-stage 64-bit integer arithmetic unit. A 7-bit function code selects the operation. The unit adds or subtracts on 32-bit (longword) or 64-bit (quadword) operands, and it can pre-scale the first operand by 4 or 8. It also performs signed and unsigned compares and a per-byte unsigned compare that returns an 8-bit lane mask. Four trapping variants raise an overflow flag when the signed result does not fit. Longword results are sign-extended from bit 31 to fill the 64-bit result.

The unit sits in an execute stage, behind the operand read and immediate select. It takes two operands, a function code and a valid strobe. One clock later it presents a registered result with valid, overflow and illegal-function flags. Trap delivery belongs to the surrounding pipeline. An unlisted function code gives a zero result and raises the illegal-function flag.

Top module: `scaled_int_alu`

## Requirements
- R1: Longword add (func 0x00) and subtract (func 0x09) use only bits 31:0 of each operand. The 32-bit result is sign-extended from bit 31 into bits 63:32.
- R2: Quadword add (func 0x20) and subtract (func 0x29) operate on all 64 bits, modulo 2^64.
- R3: Scaled forms shift the first operand left by 2 or by 3 before the add or subtract, within the operation width. Longword: 0x02 (x4 add), 0x12 (x8 add), 0x0b (x4 sub), 0x1b (x8 sub). Quadword: 0x22, 0x32, 0x2b, 0x3b, in the same order.
- R4: Trapping add (0x40 longword, 0x60 quadword) flags overflow when both operand signs match and the result sign differs from the first operand's sign. Overflow is flagged for no code other than the four trapping codes.
- R5: Trapping subtract (0x49 longword, 0x69 quadword) flags overflow when the operand signs differ and the result sign differs from the first operand's sign. On overflow the truncated result is still produced.
- R6: Compares return 1 when the condition holds and 0 otherwise, over 64 bits. The codes are 0x2d equal, 0x6d signed less-or-equal, 0x4d signed less-than, 0x3d unsigned less-or-equal and 0x1d unsigned less-than.
- R7: Function 0x0f compares each of the 8 byte lanes as unsigned values. Result bit i is 1 when byte i of the first operand is greater than or equal to byte i of the second. Bits 63:8 are zero.
- R8: Any other function code gives a zero result with the illegal flag high and the overflow flag low.
- R9: Outputs are registered. valid_o is valid_i delayed by one clock. The overflow and illegal flags are high only in a cycle where valid_o is high. After reset all outputs are zero.
- R10: A cycle with valid_i low leaves result_o unchanged, whatever the operands and function code are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| func_i | input | 7 | Function code |
| opa_i | input | 64 | First operand (the scaled one) |
| opb_i | input | 64 | Second operand |
| result_o | output | 64 | Registered result |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| ovf_o | output | 1 | Signed overflow on a trapping code |
| illegal_o | output | 1 | Unlisted function code |

## Verification
The only state is the output register. A wrong decode or a wrong datapath therefore shows at result_o or at the flags in the cycle right after the strobe, and a faulty hold shows on the first idle cycle. A cycle-accurate model in the bench predicts every output on every clock. It covers directed sign and carry boundaries at bit 31 and at bit 63, the byte-lane ties of the mask compare, and illegal codes. A long randomized run then mixes operands biased to those extremes with idle cycles.

// File: rtl/sia_pkg.sv
package sia_pkg;
  localparam int unsigned FUNC_W = 7;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_EQ, OP_LE, OP_LT, OP_ULE, OP_ULT, OP_BGE, OP_ILL
  } op_e;

  typedef struct packed {
    op_e        op;
    logic       is_long;
    logic [1:0] sh;     // left shift of first operand
    logic       trap;
  } dec_t;
endpackage

// File: rtl/sia_decode.sv
module sia_decode
  import sia_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o = '{op: OP_ILL, is_long: 1'b0, sh: 2'd0, trap: 1'b0};
    unique case (func_i)
      7'h00: dec_o = '{OP_ADD, 1'b1, 2'd0, 1'b0};
      7'h02: dec_o = '{OP_ADD, 1'b1, 2'd2, 1'b0};
      7'h12: dec_o = '{OP_ADD, 1'b1, 2'd3, 1'b0};
      7'h40: dec_o = '{OP_ADD, 1'b1, 2'd0, 1'b1};
      7'h20: dec_o = '{OP_ADD, 1'b0, 2'd0, 1'b0};
      7'h22: dec_o = '{OP_ADD, 1'b0, 2'd2, 1'b0};
      7'h32: dec_o = '{OP_ADD, 1'b0, 2'd3, 1'b0};
      7'h60: dec_o = '{OP_ADD, 1'b0, 2'd0, 1'b1};
      7'h09: dec_o = '{OP_SUB, 1'b1, 2'd0, 1'b0};
      7'h0b: dec_o = '{OP_SUB, 1'b1, 2'd2, 1'b0};
      7'h1b: dec_o = '{OP_SUB, 1'b1, 2'd3, 1'b0};
      7'h49: dec_o = '{OP_SUB, 1'b1, 2'd0, 1'b1};
      7'h29: dec_o = '{OP_SUB, 1'b0, 2'd0, 1'b0};
      7'h2b: dec_o = '{OP_SUB, 1'b0, 2'd2, 1'b0};
      7'h3b: dec_o = '{OP_SUB, 1'b0, 2'd3, 1'b0};
      7'h69: dec_o = '{OP_SUB, 1'b0, 2'd0, 1'b1};
      7'h2d: dec_o = '{OP_EQ,  1'b0, 2'd0, 1'b0};
      7'h6d: dec_o = '{OP_LE,  1'b0, 2'd0, 1'b0};
      7'h4d: dec_o = '{OP_LT,  1'b0, 2'd0, 1'b0};
      7'h3d: dec_o = '{OP_ULE, 1'b0, 2'd0, 1'b0};
      7'h1d: dec_o = '{OP_ULT, 1'b0, 2'd0, 1'b0};
      7'h0f: dec_o = '{OP_BGE, 1'b0, 2'd0, 1'b0};
      default: ;
    endcase
  end
endmodule

// File: rtl/sia_addsub.sv
module sia_addsub #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         long_i,
  input  logic [1:0]   sh_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  localparam int unsigned HW = W / 2;

  logic [W-1:0] a_sh, b_eff, sum;
  logic         sa, sb, sr;

  always_comb begin
    a_sh  = a_i << sh_i;
    b_eff = sub_i ? ~b_i : b_i;
    sum   = a_sh + b_eff + {{(W-1){1'b0}}, sub_i};
    // low half of the wide sum is exact for longword ops
    if (long_i) begin
      res_o = {{HW{sum[HW-1]}}, sum[HW-1:0]};
      sa    = a_sh[HW-1];
      sb    = b_i[HW-1];
      sr    = sum[HW-1];
    end else begin
      res_o = sum;
      sa    = a_sh[W-1];
      sb    = b_i[W-1];
      sr    = sum[W-1];
    end
    ovf_o = (sub_i ? (sa != sb) : (sa == sb)) && (sr != sa);
  end
endmodule

// File: rtl/sia_compare.sv
module sia_compare #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           eq_o,
  output logic           slt_o,
  output logic           ult_o,
  output logic [W/8-1:0] bge_o
);
  localparam int unsigned NL = W / 8;

  assign eq_o  = (a_i == b_i);
  assign slt_o = ($signed(a_i) < $signed(b_i));
  assign ult_o = (a_i < b_i);

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign bge_o[i] = (a_i[8*i +: 8] >= b_i[8*i +: 8]);
  end
endmodule

// File: rtl/scaled_int_alu.sv
module scaled_int_alu
  import sia_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [W-1:0]      opa_i,
  input  logic [W-1:0]      opb_i,
  output logic [W-1:0]      result_o,
  output logic              valid_o,
  output logic              ovf_o,
  output logic              illegal_o
);
  localparam int unsigned NL = W / 8;

  dec_t          dec;
  logic [W-1:0]  as_res, res_d;
  logic          as_ovf, eq, slt, ult;
  logic [NL-1:0] bge;

  sia_decode u_dec (.func_i(func_i), .dec_o(dec));

  sia_addsub #(.W(W)) u_as (
    .a_i(opa_i), .b_i(opb_i), .sub_i(dec.op == OP_SUB),
    .long_i(dec.is_long), .sh_i(dec.sh), .res_o(as_res), .ovf_o(as_ovf)
  );

  sia_compare #(.W(W)) u_cmp (
    .a_i(opa_i), .b_i(opb_i), .eq_o(eq), .slt_o(slt), .ult_o(ult), .bge_o(bge)
  );

  always_comb begin
    res_d = '0;
    unique case (dec.op)
      OP_ADD, OP_SUB: res_d = as_res;
      OP_EQ:  res_d[0] = eq;
      OP_LE:  res_d[0] = slt | eq;
      OP_LT:  res_d[0] = slt;
      OP_ULE: res_d[0] = ult | eq;
      OP_ULT: res_d[0] = ult;
      OP_BGE: res_d[NL-1:0] = bge;
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      valid_o   <= 1'b0;
      ovf_o     <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      ovf_o     <= valid_i && dec.trap && as_ovf;
      illegal_o <= valid_i && (dec.op == OP_ILL);
      if (valid_i) result_o <= res_d;
    end
  end
endmodule

// File: rtl/sia_checker.sv
module sia_checker #(
  parameter int unsigned W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [6:0]   func_i,
  input logic [W-1:0] result_o,
  input logic         valid_o,
  input logic         ovf_o,
  input logic         illegal_o
);
  logic is_trap, is_cmp;
  assign is_trap = (func_i == 7'h40) || (func_i == 7'h60) ||
                   (func_i == 7'h49) || (func_i == 7'h69);
  assign is_cmp  = (func_i == 7'h2d) || (func_i == 7'h6d) || (func_i == 7'h4d) ||
                   (func_i == 7'h3d) || (func_i == 7'h1d);

  a_r9_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r9_idle_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r9_flags_need_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o || illegal_o) |-> valid_o);
  a_r8_illegal_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == '0 && !ovf_o));
  a_r4_trap_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_trap) |=> !ovf_o);
  a_r6_boolean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_cmp) |=> (result_o[W-1:1] == '0));
  a_r7_mask_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && func_i == 7'h0f) |=> (result_o[W-1:8] == '0));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
endmodule

bind scaled_int_alu sia_checker #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .func_i(func_i),
  .result_o(result_o), .valid_o(valid_o), .ovf_o(ovf_o), .illegal_o(illegal_o)
);

// File: tb/scaled_int_alu_bench.sv
module scaled_int_alu_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [6:0]  func_i = '0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic [63:0] result_o;
  logic        valid_o, ovf_o, illegal_o;

  int checks = 0, failures = 0;
  int cycles = 0;
  bit done = 0;

  logic [63:0] e_res = '0;
  logic        e_val = 0, e_ovf = 0, e_ill = 0;
  string       e_tag = "R9";

  always #4 clk_i = ~clk_i;

  scaled_int_alu u_scaled_int_alu (.*);

  // behavioural reference
  task automatic ref_op(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                        output logic [63:0] r, output logic ov, output logic il);
    longint sa, sb, w32;
    logic signed [66:0] w;
    int mul; bit sub, lng, trp, arith;
    r = '0; ov = 0; il = 0; arith = 1; trp = 0; mul = 1; sub = 0; lng = 0;
    case (f)
      7'h00: lng = 1;  7'h02: begin lng = 1; mul = 4; end
      7'h12: begin lng = 1; mul = 8; end  7'h40: begin lng = 1; trp = 1; end
      7'h20: ;  7'h22: mul = 4;  7'h32: mul = 8;  7'h60: trp = 1;
      7'h09: begin lng = 1; sub = 1; end  7'h0b: begin lng = 1; sub = 1; mul = 4; end
      7'h1b: begin lng = 1; sub = 1; mul = 8; end
      7'h49: begin lng = 1; sub = 1; trp = 1; end
      7'h29: sub = 1;  7'h2b: begin sub = 1; mul = 4; end
      7'h3b: begin sub = 1; mul = 8; end  7'h69: begin sub = 1; trp = 1; end
      default: arith = 0;
    endcase
    if (arith && lng) begin
      sa = longint'($signed(a[31:0])); sb = longint'($signed(b[31:0]));
      w32 = sub ? sa * mul - sb : sa * mul + sb;
      r = {{32{w32[31]}}, w32[31:0]};
      ov = trp && (w32 > 64'sd2147483647 || w32 < -64'sd2147483648);
    end else if (arith) begin
      w = $signed({{3{a[63]}}, a}) * mul;
      w = sub ? w - $signed({{3{b[63]}}, b}) : w + $signed({{3{b[63]}}, b});
      r = w[63:0];
      ov = trp && !(w[66:63] == 4'h0 || w[66:63] == 4'hf);
    end else begin
      case (f)
        7'h2d: r = {63'd0, a == b};
        7'h6d: r = {63'd0, $signed(a) <= $signed(b)};
        7'h4d: r = {63'd0, $signed(a) < $signed(b)};
        7'h3d: r = {63'd0, a <= b};
        7'h1d: r = {63'd0, a < b};
        7'h0f: for (int i = 0; i < 8; i++) r[i] = (a[8*i +: 8] >= b[8*i +: 8]);
        default: il = 1;
      endcase
    end
  endtask

  task automatic check_now();
    checks++;
    if (valid_o !== e_val || ovf_o !== e_ovf || illegal_o !== e_ill || result_o !== e_res) begin
      failures++;
      $display("FAIL %s: got res=%h v=%b ov=%b il=%b exp res=%h v=%b ov=%b il=%b",
               e_tag, result_o, valid_o, ovf_o, illegal_o, e_res, e_val, e_ovf, e_ill);
    end
  endtask

  // check previous cycle, then drive next operation
  task automatic step(input bit v, input logic [6:0] f, input logic [63:0] a,
                      input logic [63:0] b, input string tag);
    logic [63:0] r; logic ov, il;
    @(negedge clk_i);
    check_now();
    valid_i = v; func_i = f; opa_i = a; opb_i = b;
    ref_op(f, a, b, r, ov, il);
    e_val = v; e_tag = tag;
    e_ovf = v && ov; e_ill = v && il;
    if (v) e_res = r;
  endtask

  function automatic logic [63:0] pick();
    case ($urandom_range(0, 7))
      0: return 64'h7fff_ffff_ffff_ffff;
      1: return 64'h8000_0000_0000_0000;
      2: return {32'h0, 32'h7fff_ffff};
      3: return {32'hffff_ffff, 32'h8000_0000};
      4: return 64'hffff_ffff_ffff_ffff;
      5: return 64'($urandom_range(0, 3));
      default: return {$urandom, $urandom};
    endcase
  endfunction

  logic [6:0] codes [22] = '{7'h00, 7'h02, 7'h12, 7'h40, 7'h20, 7'h22, 7'h32, 7'h60,
                             7'h09, 7'h0b, 7'h1b, 7'h49, 7'h29, 7'h2b, 7'h3b, 7'h69,
                             7'h2d, 7'h6d, 7'h4d, 7'h3d, 7'h1d, 7'h0f};

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    checks++;
    if (result_o !== '0 || valid_o !== 0 || ovf_o !== 0 || illegal_o !== 0) begin
      failures++;
      $display("FAIL R9 reset: res=%h v=%b ov=%b il=%b exp all zero", result_o, valid_o, ovf_o, illegal_o);
    end
    rst_ni = 1'b1;
    step(0, 7'h00, 0, 0, "R9");
    // R1
    step(1, 7'h00, 64'h0000_0000_7fff_ffff, 64'h1, "R1");
    step(1, 7'h00, 64'hdead_beef_0000_0005, 64'h1234_5678_0000_0003, "R1");
    step(1, 7'h09, 64'h0, 64'h1, "R1");
    // R2
    step(1, 7'h20, 64'hffff_ffff_ffff_ffff, 64'h2, "R2");
    step(1, 7'h29, 64'h1_0000_0000, 64'h1, "R2");
    // R3
    step(1, 7'h12, 64'h3, 64'h1, "R3");
    step(1, 7'h02, 64'h4000_0001, 64'h0, "R3");
    step(1, 7'h3b, 64'h1, 64'd10, "R3");
    step(1, 7'h2b, 64'h4000_0000_0000_0001, 64'h1, "R3");
    step(1, 7'h1b, 64'h2000_0000, 64'h0, "R3");
    step(1, 7'h32, 64'h2000_0000_0000_0000, 64'h0, "R3");
    // R4
    step(1, 7'h40, 64'h7fff_ffff, 64'h1, "R4");
    step(1, 7'h00, 64'h7fff_ffff, 64'h1, "R4");
    step(1, 7'h60, 64'h7fff_ffff_ffff_ffff, 64'h1, "R4");
    step(1, 7'h60, 64'h8000_0000_0000_0000, 64'hffff_ffff_ffff_ffff, "R4");
    step(1, 7'h60, 64'h7fff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, "R4");
    step(1, 7'h20, 64'h7fff_ffff_ffff_ffff, 64'h1, "R4");
    // R5
    step(1, 7'h49, 64'h8000_0000, 64'h1, "R5");
    step(1, 7'h49, 64'hffff_ffff, 64'h1, "R5");
    step(1, 7'h69, 64'h8000_0000_0000_0000, 64'h1, "R5");
    step(1, 7'h69, 64'h7fff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, "R5");
    step(1, 7'h29, 64'h8000_0000_0000_0000, 64'h1, "R5");
    // R6
    step(1, 7'h2d, 64'h55, 64'h55, "R6");
    step(1, 7'h6d, 64'hffff_ffff_ffff_ffff, 64'h0, "R6");
    step(1, 7'h4d, 64'h5, 64'h5, "R6");
    step(1, 7'h3d, 64'hffff_ffff_ffff_ffff, 64'h0, "R6");
    step(1, 7'h1d, 64'h0, 64'hffff_ffff_ffff_ffff, "R6");
    step(1, 7'h6d, 64'h5, 64'h5, "R6");
    // R7
    step(1, 7'h0f, 64'h00ff_1080_7f01_0203, 64'h01fe_1081_7f00_0302, "R7");
    step(1, 7'h0f, 64'hffff_ffff_ffff_ffff, 64'h0, "R7");
    // R8
    step(1, 7'h7f, 64'h1234, 64'h5678, "R8");
    step(1, 7'h01, 64'h7fff_ffff, 64'h1, "R8");
    // R10
    step(1, 7'h20, 64'h1111, 64'h2222, "R10");
    step(0, 7'h20, 64'h9, 64'h9, "R10");
    step(0, 7'h7f, 64'h3, 64'h4, "R10");
    step(1, 7'h0f, 64'h0, 64'h0, "R10");
    // randomized mix
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] f;
      f = ($urandom_range(0, 9) == 0) ? 7'($urandom) : codes[$urandom_range(0, 21)];
      step($urandom_range(0, 5) != 0, f, pick(), pick(), "R1-mix");
    end
    step(0, 7'h00, 0, 0, "R9");
    @(negedge clk_i);
    check_now();
    done = 1;
  end

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk_i);
      cycles++;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout at %0d cycles, expected completion", cycles);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule